// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control state of a processor core: a status word with a current byte and a backup byte, a second-level backup status byte, a separate condition bit, two stack pointers kept in banks (one for interrupt mode, one for user mode), two backup program counters and two plain scratch words. It has two ports. The first is an indexed control-register port with a combinational read and a registered write. The second reads and writes the live stack pointer, which is the stack pointer the general register file uses.

Bit 7 of the current status byte selects the stack mode. When a status write changes that bit, the block exchanges the live stack pointer with the banked copy for the new mode in the same clock edge. While a mode is active, its own banked stack pointer is an alias of the live pointer. Reads of the status, backup-status and backup-PC registers return packed or masked views of the stored bits.

Top module: `ctrl_bank_regfile`

## Requirements
- R1: After reset every stored value is zero. Every control-register read returns 0 and the live stack pointer reads 0.
- R2: Reading index 0 (status) returns the backup status byte ANDed with 0xC1 in bits 15:8, the current status byte ANDed with 0xC0 in bits 7:0 with the condition bit ORed into bit 0, and zero in bits 31:16.
- R3: Writing index 0 loads the backup status byte from bits 15:8 and the current status byte from bits 7:0, and sets the condition bit from bit 0.
- R4: A status write that takes bit 7 of the current byte from 0 to 1 copies the old live stack pointer into the user stack pointer and loads the live stack pointer from the interrupt stack pointer.
- R5: A status write that takes bit 7 from 1 to 0 copies the old live stack pointer into the interrupt stack pointer and loads the live stack pointer from the user stack pointer.
- R6: A status write that leaves bit 7 unchanged does not move any stack pointer.
- R7: Index 8 (second-level backup status) stores bits 7:0 of a write. A read returns that byte ANDed with 0xC1.
- R8: Index 1 (condition) writes and reads only bit 0. The same bit shows in bit 0 of a status read.
- R9: Indices 6 and 9 (backup PC and second-level backup PC) store all 32 bits. A read returns them with bit 0 forced to 0.
- R10: Indices 4 and 5 are plain 32-bit storage with no side effects.
- R11: Index 2 (interrupt stack pointer) in stack mode 1, and index 3 (user stack pointer) in stack mode 0, read and write the live stack pointer. In the other mode each reaches its banked copy.
- R12: Indices 7 and 10 to 15 read as 0, and writes to them change no state.
- R13: A write becomes visible on the clock edge that samples its strobe. Before that edge the read shows the old value.
- R14: When a control write in the same cycle also changes the live stack pointer (through a mode swap or an alias), it takes priority over the stack-pointer port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_idx | input | 4 | Control-register index for read and write |
| cr_wdata | input | 32 | Control-register write data |
| cr_rdata | output | 32 | Control-register read data, combinational from cr_idx |
| sp_wr_en | input | 1 | Live stack-pointer write strobe |
| sp_wdata | input | 32 | Live stack-pointer write data |
| sp_rdata | output | 32 | Live stack-pointer value |

## Verification
If the stack-mode bit held the wrong value, the error would appear at the ports on the next status write. The live pointer would then be swapped in the wrong direction or not at all, and sp_rdata would show it one edge after the write. A wrong banked pointer stays hidden until a mode change brings it live, or until the index of the inactive bank is read, so the stimulus reads both banks in both modes. A masking fault in the status, backup-status or backup-PC views shows up combinationally on the first read of that index.

// File: rtl/ctrl_bank_pkg.sv
package ctrl_bank_pkg;
  localparam int DW     = 32;
  localparam int BW     = 8;
  localparam int IDX_W  = 4;
  localparam int NUM_SCR = 2;

  localparam logic [IDX_W-1:0] IDX_STATUS = 4'd0;
  localparam logic [IDX_W-1:0] IDX_COND   = 4'd1;
  localparam logic [IDX_W-1:0] IDX_ISP    = 4'd2;
  localparam logic [IDX_W-1:0] IDX_USP    = 4'd3;
  localparam logic [IDX_W-1:0] IDX_SCR0   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_SCR1   = 4'd5;
  localparam logic [IDX_W-1:0] IDX_BPC    = 4'd6;
  localparam logic [IDX_W-1:0] IDX_BBPSW  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_BBPC   = 4'd9;

  localparam logic [BW-1:0] BAK_MASK = 8'hC1;
  localparam logic [BW-1:0] CUR_MASK = 8'hC0;
  localparam int MODE_BIT = 7;

  typedef struct packed {
    logic [BW-1:0]             psw_bak;
    logic [BW-1:0]             psw_cur;
    logic [BW-1:0]             bbpsw;
    logic                      cond;
    logic [DW-1:0]             sp;
    logic [DW-1:0]             isp;
    logic [DW-1:0]             usp;
    logic [DW-1:0]             bpc;
    logic [DW-1:0]             bbpc;
    logic [NUM_SCR-1:0][DW-1:0] scr;
  } cr_state_t;
endpackage

// File: rtl/cr_rst_sync.sv
module cr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cr_read_mux.sv
module cr_read_mux
  import ctrl_bank_pkg::*;
(
  input  cr_state_t        st,
  input  logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    rdata
);
  logic mode;
  assign mode = st.psw_cur[MODE_BIT];

  always_comb begin
    rdata = '0;
    unique case (idx)
      IDX_STATUS: rdata = {{(DW-2*BW){1'b0}}, st.psw_bak & BAK_MASK,
                           (st.psw_cur & CUR_MASK) | {{(BW-1){1'b0}}, st.cond}};
      IDX_COND:   rdata = {{(DW-1){1'b0}}, st.cond};
      IDX_ISP:    rdata = mode ? st.sp : st.isp;
      IDX_USP:    rdata = mode ? st.usp : st.sp;
      IDX_SCR0:   rdata = st.scr[0];
      IDX_SCR1:   rdata = st.scr[1];
      IDX_BPC:    rdata = {st.bpc[DW-1:1], 1'b0};
      IDX_BBPSW:  rdata = {{(DW-BW){1'b0}}, st.bbpsw & BAK_MASK};
      IDX_BBPC:   rdata = {st.bbpc[DW-1:1], 1'b0};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/cr_write_next.sv
module cr_write_next
  import ctrl_bank_pkg::*;
(
  input  cr_state_t        cur,
  input  logic             cr_wr_en,
  input  logic [IDX_W-1:0] cr_idx,
  input  logic [DW-1:0]    cr_wdata,
  input  logic             sp_wr_en,
  input  logic [DW-1:0]    sp_wdata,
  output cr_state_t        nxt
);
  logic mode_now;
  logic mode_new;
  assign mode_now = cur.psw_cur[MODE_BIT];
  assign mode_new = cr_wdata[MODE_BIT];

  always_comb begin
    nxt = cur;
    // Stack-pointer port first; a control write below overrides it (R14).
    if (sp_wr_en) nxt.sp = sp_wdata;
    if (cr_wr_en) begin
      unique case (cr_idx)
        IDX_STATUS: begin
          nxt.psw_bak = cr_wdata[2*BW-1:BW];
          nxt.psw_cur = cr_wdata[BW-1:0];
          nxt.cond    = cr_wdata[0];
          if (!mode_now && mode_new) begin
            nxt.usp = cur.sp;
            nxt.sp  = cur.isp;
          end else if (mode_now && !mode_new) begin
            nxt.isp = cur.sp;
            nxt.sp  = cur.usp;
          end
        end
        IDX_COND:  nxt.cond = cr_wdata[0];
        IDX_ISP:   if (mode_now) nxt.sp = cr_wdata; else nxt.isp = cr_wdata;
        IDX_USP:   if (mode_now) nxt.usp = cr_wdata; else nxt.sp = cr_wdata;
        IDX_SCR0:  nxt.scr[0] = cr_wdata;
        IDX_SCR1:  nxt.scr[1] = cr_wdata;
        IDX_BPC:   nxt.bpc = cr_wdata;
        IDX_BBPSW: nxt.bbpsw = cr_wdata[BW-1:0];
        IDX_BBPC:  nxt.bbpc = cr_wdata;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/ctrl_bank_regfile.sv
module ctrl_bank_regfile
  import ctrl_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cr_wr_en,
  input  logic [IDX_W-1:0] cr_idx,
  input  logic [DW-1:0]    cr_wdata,
  output logic [DW-1:0]    cr_rdata,
  input  logic             sp_wr_en,
  input  logic [DW-1:0]    sp_wdata,
  output logic [DW-1:0]    sp_rdata
);
  logic      rst_sync_n;
  cr_state_t state_q;
  cr_state_t state_d;
  logic      upd_en;

  cr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cr_write_next u_next (
    .cur      (state_q),
    .cr_wr_en (cr_wr_en),
    .cr_idx   (cr_idx),
    .cr_wdata (cr_wdata),
    .sp_wr_en (sp_wr_en),
    .sp_wdata (sp_wdata),
    .nxt      (state_d)
  );

  assign upd_en = cr_wr_en | sp_wr_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  state_q <= '0;
    else if (upd_en)  state_q <= state_d;
  end

  cr_read_mux u_read (
    .st    (state_q),
    .idx   (cr_idx),
    .rdata (cr_rdata)
  );

  assign sp_rdata = state_q.sp;
endmodule

// File: rtl/ctrl_bank_checker.sv
module ctrl_bank_checker
  import ctrl_bank_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cr_wr_en,
  input logic [IDX_W-1:0] cr_idx,
  input logic [DW-1:0]    cr_wdata,
  input logic [DW-1:0]    cr_rdata,
  input logic             sp_wr_en,
  input logic [DW-1:0]    sp_rdata,
  input logic             mode,
  input logic [DW-1:0]    isp_q,
  input logic [DW-1:0]    usp_q
);
  logic status_wr;
  assign status_wr = cr_wr_en && (cr_idx == IDX_STATUS);

  assert_swap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && !mode && cr_wdata[MODE_BIT])
      |=> (sp_rdata == $past(isp_q)) && (usp_q == $past(sp_rdata)));

  assert_swap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && mode && !cr_wdata[MODE_BIT])
      |=> (sp_rdata == $past(usp_q)) && (isp_q == $past(sp_rdata)));

  assert_sp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cr_wr_en && !sp_wr_en) |=> $stable(sp_rdata));

  assert_bbpsw_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_idx == IDX_BBPSW) |-> ((cr_rdata & ~{{(DW-BW){1'b0}}, BAK_MASK}) == '0));

  assert_bpc_lsb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cr_idx == IDX_BPC) || (cr_idx == IDX_BBPC)) |-> (cr_rdata[0] == 1'b0));

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((cr_idx == 4'd7) || (cr_idx >= 4'd10)) |-> (cr_rdata == '0));
endmodule

bind ctrl_bank_regfile ctrl_bank_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cr_wr_en (cr_wr_en),
  .cr_idx   (cr_idx),
  .cr_wdata (cr_wdata),
  .cr_rdata (cr_rdata),
  .sp_wr_en (sp_wr_en),
  .sp_rdata (sp_rdata),
  .mode     (state_q.psw_cur[7]),
  .isp_q    (state_q.isp),
  .usp_q    (state_q.usp)
);

// File: tb/ctrl_bank_regfile_bench.sv
module ctrl_bank_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cr_wr_en;
  logic [3:0]  cr_idx;
  logic [31:0] cr_wdata;
  logic [31:0] cr_rdata;
  logic        sp_wr_en;
  logic [31:0] sp_wdata;
  logic [31:0] sp_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctrl_bank_regfile u_ctrl_bank_regfile (
    .clk(clk), .rst_n(rst_n), .cr_wr_en(cr_wr_en), .cr_idx(cr_idx),
    .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .sp_wr_en(sp_wr_en),
    .sp_wdata(sp_wdata), .sp_rdata(sp_rdata)
  );

  // op: 0 control write, 1 control read check, 2 sp write, 3 sp read check
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  idx;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 4'd0, 32'h0000_0000, 4'd1},   // R1
    '{2'd1, 4'd2, 32'h0000_0000, 4'd1},
    '{2'd3, 4'd0, 32'h0000_0000, 4'd1},
    '{2'd2, 4'd0, 32'h1000_0000, 4'd11},
    '{2'd0, 4'd2, 32'h2000_0000, 4'd11},  // R11 banked isp in mode 0
    '{2'd1, 4'd2, 32'h2000_0000, 4'd11},
    '{2'd1, 4'd3, 32'h1000_0000, 4'd11},  // usp alias in mode 0
    '{2'd0, 4'd0, 32'h0000_FF81, 4'd4},   // R4 mode 0->1
    '{2'd3, 4'd0, 32'h2000_0000, 4'd4},
    '{2'd1, 4'd0, 32'h0000_C181, 4'd2},   // R2 packing
    '{2'd1, 4'd3, 32'h1000_0000, 4'd4},
    '{2'd1, 4'd2, 32'h2000_0000, 4'd11},
    '{2'd0, 4'd0, 32'h0000_00C0, 4'd6},   // R6 mode stays 1
    '{2'd1, 4'd0, 32'h0000_00C0, 4'd3},   // R3
    '{2'd3, 4'd0, 32'h2000_0000, 4'd6},
    '{2'd1, 4'd3, 32'h1000_0000, 4'd6},
    '{2'd0, 4'd2, 32'h3000_0000, 4'd11},  // isp alias in mode 1
    '{2'd3, 4'd0, 32'h3000_0000, 4'd11},
    '{2'd0, 4'd0, 32'h0000_0001, 4'd5},   // R5 mode 1->0
    '{2'd3, 4'd0, 32'h1000_0000, 4'd5},
    '{2'd1, 4'd2, 32'h3000_0000, 4'd5},
    '{2'd1, 4'd0, 32'h0000_0001, 4'd3},
    '{2'd0, 4'd1, 32'hFFFF_FFFE, 4'd8},   // R8
    '{2'd1, 4'd1, 32'h0000_0000, 4'd8},
    '{2'd1, 4'd0, 32'h0000_0000, 4'd8},
    '{2'd0, 4'd1, 32'h0000_0003, 4'd8},
    '{2'd1, 4'd1, 32'h0000_0001, 4'd8},
    '{2'd0, 4'd8, 32'hABCD_12FF, 4'd7},   // R7
    '{2'd1, 4'd8, 32'h0000_00C1, 4'd7},
    '{2'd0, 4'd6, 32'h1234_5677, 4'd9},   // R9
    '{2'd1, 4'd6, 32'h1234_5676, 4'd9},
    '{2'd0, 4'd9, 32'hFFFF_FFFF, 4'd9},
    '{2'd1, 4'd9, 32'hFFFF_FFFE, 4'd9},
    '{2'd0, 4'd4, 32'hDEAD_BEEF, 4'd10},  // R10
    '{2'd0, 4'd5, 32'h0BAD_F00D, 4'd10},
    '{2'd1, 4'd4, 32'hDEAD_BEEF, 4'd10},
    '{2'd1, 4'd5, 32'h0BAD_F00D, 4'd10},
    '{2'd0, 4'd7, 32'hFFFF_FFFF, 4'd12},  // R12
    '{2'd1, 4'd7, 32'h0000_0000, 4'd12},
    '{2'd0, 4'd15, 32'hFFFF_FFFF, 4'd12},
    '{2'd1, 4'd15, 32'h0000_0000, 4'd12},
    '{2'd1, 4'd0, 32'h0000_0001, 4'd12},
    '{2'd1, 4'd4, 32'hDEAD_BEEF, 4'd12},
    '{2'd1, 4'd8, 32'h0000_00C1, 4'd12},
    '{2'd3, 4'd0, 32'h1000_0000, 4'd12}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    @(negedge clk);
    cr_idx = v.idx;
    case (v.op)
      2'd0: begin cr_wr_en = 1'b1; cr_wdata = v.data; end
      2'd2: begin sp_wr_en = 1'b1; sp_wdata = v.data; end
      default: ;
    endcase
    #1;
    if (v.op == 2'd1) check($sformatf("R%0d cr[%0d]", v.req, v.idx), cr_rdata, v.data);
    if (v.op == 2'd3) check($sformatf("R%0d sp", v.req), sp_rdata, v.data);
    @(posedge clk); #1;
    cr_wr_en = 1'b0; sp_wr_en = 1'b0;
  endtask

  function automatic vec_t mk(input logic [1:0] op, input logic [3:0] idx,
                              input logic [31:0] d, input logic [3:0] r);
    return '{op, idx, d, r};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cr_wr_en = 1'b0; cr_idx = '0; cr_wdata = '0;
    sp_wr_en = 1'b0; sp_wdata = '0;
    do_reset();
    for (int i = 0; i < NV; i++) run_op(VEC[i]);

    // R13: write visible only after the sampling edge
    @(negedge clk);
    cr_idx = 4'd4; cr_wr_en = 1'b1; cr_wdata = 32'h5555_AAAA; #1;
    check("R13 before edge", cr_rdata, 32'hDEAD_BEEF);
    @(posedge clk); #1;
    cr_wr_en = 1'b0;
    check("R13 after edge", cr_rdata, 32'h5555_AAAA);

    // R14: usp alias (mode 0) write beats sp port write
    @(negedge clk);
    cr_idx = 4'd3; cr_wr_en = 1'b1; cr_wdata = 32'h0000_0A0A;
    sp_wr_en = 1'b1; sp_wdata = 32'h0000_0B0B;
    @(posedge clk); #1;
    cr_wr_en = 1'b0; sp_wr_en = 1'b0;
    check("R14 alias wins", sp_rdata, 32'h0000_0A0A);

    // R14: mode swap 0->1 beats sp port write; sp <- isp (0x30000000)
    @(negedge clk);
    cr_idx = 4'd0; cr_wr_en = 1'b1; cr_wdata = 32'h0000_0080;
    sp_wr_en = 1'b1; sp_wdata = 32'h0000_0C0C;
    @(posedge clk); #1;
    cr_wr_en = 1'b0; sp_wr_en = 1'b0;
    check("R14 swap wins", sp_rdata, 32'h3000_0000);
    run_op(mk(2'd1, 4'd3, 32'h0000_0A0A, 4'd4)); // R4 usp holds old live sp

    // R6 + R14: status write without mode change lets sp port through
    @(negedge clk);
    cr_idx = 4'd0; cr_wr_en = 1'b1; cr_wdata = 32'h0000_0080;
    sp_wr_en = 1'b1; sp_wdata = 32'h0000_0D0D;
    @(posedge clk); #1;
    cr_wr_en = 1'b0; sp_wr_en = 1'b0;
    check("R6 sp port applies", sp_rdata, 32'h0000_0D0D);

    // R1: reset in mid-run clears everything
    do_reset();
    run_op(mk(2'd3, 4'd0, 32'h0, 4'd1));
    run_op(mk(2'd1, 4'd0, 32'h0, 4'd1));
    run_op(mk(2'd1, 4'd3, 32'h0, 4'd1));
    run_op(mk(2'd1, 4'd4, 32'h0, 4'd1));
    run_op(mk(2'd1, 4'd6, 32'h0, 4'd1));
    run_op(mk(2'd1, 4'd1, 32'h0, 4'd1));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule